// File: doc/BRIEF.md
# Processor Core Timer Status and Control Unit

This unit gives an embedded processor core three timer event sources. A 32-bit decrementer counts down once per timebase tick. It halts at zero and never wraps. Two further events come from a free-running timebase value that arrives from outside the unit: a fixed-interval event and a watchdog event. Each one fires on the rising transition of a timebase bit that a 2-bit period select in the control register chooses.

Every event sets a sticky flag in a status register. Software clears a flag by writing a one to its bit. Each event source drives a level interrupt output, which is the AND of its sticky flag and its enable bit in the control register. If a flag is still pending when software sets the enable, the interrupt asserts immediately. Software reaches the decrementer, the control register and the status register through a single-cycle write port and a combinational read port.

Top module: `tmr_unit`

## Requirements
- R1: After reset the decrementer, control and status registers all read zero, and all three interrupt outputs are low.
- R2: Each clock cycle with `tb_tick` high, a nonzero decrementer decreases by exactly one. At zero it stays at zero and never wraps.
- R3: The decrementer flag (status bit 28) is set only when counting takes the decrementer from 1 to 0. Loading zero does not set it. Loading a value with bit 31 set does not set it either, because that bit has no special meaning.
- R4: A write to the status register (address 2) clears each flag whose written bit is 1 and leaves flags written as 0 unchanged. If an event and a clear of the same flag occur in the same cycle, the flag is set.
- R5: The control register (address 1) stores only bits 31:22, and bits 21:0 read as zero. Only status bits 31:27 are implemented, and bits 26:0 read as zero. Reading address 3 returns zero.
- R6: Each interrupt is high exactly while its flag and its enable are both set. The enables are control bits 26 (decrementer), 23 (fixed-interval) and 27 (watchdog). If the decrementer expires while its enable is clear, the flag is set and no interrupt is raised. Setting the enable later raises the interrupt in the cycle after that control write.
- R7: The fixed-interval flag (status bit 27) is set one clock after timebase bit `FIT_BASE + sel` rises, where `sel` is control bits 25:24. Rises on bits that are not selected have no effect.
- R8: A watchdog event is a rise of timebase bit `WDT_BASE + sel`, where `sel` is control bits 31:30. The first event, with status bit 31 clear, sets only bit 31. A later event with bit 31 set sets the watchdog flag (bit 29) and bit 30.
- R9: A control write that changes a period select takes effect on the next cycle. It creates no event from a selected bit that is steady high.
- R10: A decrementer write (address 0) loads the written value in that cycle and overrides any tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 decrementer, 1 control, 2 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes; 3 reads zero |
| rd_data | output | 32 | Combinational read data |
| tb_tick | input | 1 | Decrementer count enable, one pulse per timebase tick |
| tb_val | input | TB_W | Free-running timebase value |
| irq_dec | output | 1 | Decrementer interrupt level |
| irq_fit | output | 1 | Fixed-interval interrupt level |
| irq_wdt | output | 1 | Watchdog interrupt level |

## Verification
The assertions check these properties on every cycle:
- the decrementer steps by one and never leaves zero except by a load;
- the decrementer flag rises only after a counted step from 1;
- a pending flag and an asserted interrupt persist until a clearing write;
- the read port returns zero in the unimplemented bit positions.

Only the bench scenarios can show the following:
- a late enable raising the interrupt at once;
- the tap chosen by each period select and the absence of a false event when the select changes;
- the two-step watchdog progression;
- set-over-clear priority within one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_W  = 32;
  localparam int CTRL_W = 10;
  localparam int STAT_W = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    A_DEC  = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } tmr_addr_e;

  // occupies register bits 31:22, MSB first
  typedef struct packed {
    logic [SEL_W-1:0] wsel;
    logic [1:0]       wrc;
    logic             wie;
    logic             die;
    logic [SEL_W-1:0] fsel;
    logic             fie;
    logic             arl;
  } ctrl_t;

  // occupies register bits 31:27, bit 26 reserved
  typedef struct packed {
    logic wns1;
    logic wns0;
    logic wdt;
    logic dec;
    logic fit;
  } stat_t;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_decr.sv
module tmr_decr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  output logic [W-1:0] count_q,
  output logic         expire
);
  logic [W-1:0] count_d;
  logic         nonzero;
  logic         cnt_en;

  always_comb begin
    nonzero = (count_q != '0);
    cnt_en  = ld_en | (tick & nonzero);
    count_d = count_q;
    if (ld_en)             count_d = ld_val;
    else if (tick && nonzero) count_d = count_q - 1'b1;
    expire  = !ld_en && tick && (count_q == W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end
endmodule

// File: rtl/tmr_tap_evt.sv
module tmr_tap_evt #(
  parameter int TB_W  = 16,
  parameter int BASE  = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_val,
  input  logic [SEL_W-1:0] sel,
  output logic             evt
);
  localparam int IW = $clog2(TB_W);

  logic [TB_W-1:0] prev_q;
  logic [TB_W-1:0] rising;
  logic [IW-1:0]   idx;

  always_comb begin
    rising = tb_val & ~prev_q;
    idx    = IW'(BASE) + IW'(sel);
    evt    = rising[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= tb_val;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int TB_W     = 16,
  parameter int FIT_BASE = 2,
  parameter int WDT_BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             tb_tick,
  input  logic [TB_W-1:0]  tb_val,
  output logic             irq_dec,
  output logic             irq_fit,
  output logic             irq_wdt
);
  localparam int CTRL_LSB = REG_W - CTRL_W;
  localparam int STAT_LSB = REG_W - STAT_W;

  logic rst_sync_n;
  logic wr_dec, wr_ctrl, wr_stat;
  ctrl_t ctrl_q, ctrl_d;
  stat_t stat_q, stat_d, stat_clr;
  logic  stat_en;
  logic [REG_W-1:0] dec_q;
  logic dec_expire, fit_evt, wdt_evt;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    wr_dec  = wr_en && (wr_addr == A_DEC);
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_stat = wr_en && (wr_addr == A_STAT);
  end

  tmr_decr #(.W(REG_W)) u_decr (
    .clk(clk), .rst_n(rst_sync_n), .ld_en(wr_dec), .ld_val(wr_data),
    .tick(tb_tick), .count_q(dec_q), .expire(dec_expire)
  );

  tmr_tap_evt #(.TB_W(TB_W), .BASE(FIT_BASE), .SEL_W(SEL_W)) u_fit (
    .clk(clk), .rst_n(rst_sync_n), .tb_val(tb_val), .sel(ctrl_q.fsel), .evt(fit_evt)
  );

  tmr_tap_evt #(.TB_W(TB_W), .BASE(WDT_BASE), .SEL_W(SEL_W)) u_wdt (
    .clk(clk), .rst_n(rst_sync_n), .tb_val(tb_val), .sel(ctrl_q.wsel), .evt(wdt_evt)
  );

  // control register
  always_comb begin
    ctrl_d = ctrl_t'(wr_data[REG_W-1:CTRL_LSB]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (!rst_sync_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  // status register: clear first, then events set (set wins)
  always_comb begin
    stat_clr = wr_stat ? stat_t'(wr_data[REG_W-1:STAT_LSB]) : '0;
    stat_d   = stat_q & ~stat_clr;
    if (dec_expire) stat_d.dec = 1'b1;
    if (fit_evt)    stat_d.fit = 1'b1;
    if (wdt_evt) begin
      if (!stat_q.wns1) begin
        stat_d.wns1 = 1'b1;
      end else begin
        stat_d.wdt  = 1'b1;
        stat_d.wns0 = 1'b1;
      end
    end
    stat_en = wr_stat | dec_expire | fit_evt | wdt_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           stat_q <= '0;
    else if (!rst_sync_n) stat_q <= '0;
    else if (stat_en)     stat_q <= stat_d;
  end

  // interrupt levels
  always_comb begin
    irq_dec = stat_q.dec & ctrl_q.die;
    irq_fit = stat_q.fit & ctrl_q.fie;
    irq_wdt = stat_q.wdt & ctrl_q.wie;
  end

  // read port
  always_comb begin
    unique case (rd_addr)
      A_DEC:   rd_data = dec_q;
      A_CTRL:  rd_data = {ctrl_q, {CTRL_LSB{1'b0}}};
      A_STAT:  rd_data = {stat_q, {STAT_LSB{1'b0}}};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [1:0]  rd_addr,
  input logic [31:0] rd_data,
  input logic        tb_tick,
  input logic [31:0] dec_q,
  input logic        stat_dec,
  input logic        irq_dec
);
  logic wr_dec_c, clr_dec_c;
  always_comb begin
    wr_dec_c  = wr_en && (wr_addr == 2'd0);
    clr_dec_c = wr_en && (wr_addr == 2'd2) && wr_data[28];
  end

  AST_DEC_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q == 32'd0 && !wr_dec_c) |=> (dec_q == 32'd0)); // R2

  AST_DEC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q != 32'd0 && tb_tick && !wr_dec_c) |=> (dec_q == $past(dec_q) - 32'd1)); // R2

  AST_DEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dec_c |=> (dec_q == $past(wr_data))); // R10

  AST_DEC_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_dec) |-> ($past(dec_q) == 32'd1 && $past(tb_tick) && !$past(wr_dec_c))); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_dec && !clr_dec_c) |=> stat_dec); // R4

  AST_IRQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dec && !wr_en) |=> irq_dec); // R6

  AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> (rd_data[26:0] == 27'd0)); // R5

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data[21:0] == 22'd0)); // R5
endmodule

bind tmr_unit tmr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tb_tick(tb_tick),
  .dec_q(dec_q), .stat_dec(stat_q.dec), .irq_dec(irq_dec)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        tb_tick;
  logic [15:0] tb_val;
  logic        irq_dec, irq_fit, irq_wdt;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  tmr_unit #(.TB_W(16), .FIT_BASE(2), .WDT_BASE(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tb_tick(tb_tick), .tb_val(tb_val),
    .irq_dec(irq_dec), .irq_fit(irq_fit), .irq_wdt(irq_wdt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
      $finish;
    end
  end

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 2'd1, 32'hFFFF_FFFF}, '{1'b0, 2'd1, 32'hFFC0_0000},
    '{1'b1, 2'd1, 32'h0000_0000}, '{1'b0, 2'd1, 32'h0000_0000},
    '{1'b1, 2'd0, 32'h8000_0000}, '{1'b0, 2'd0, 32'h8000_0000},
    '{1'b0, 2'd2, 32'h0000_0000}, '{1'b1, 2'd0, 32'h0000_0000},
    '{1'b0, 2'd2, 32'h0000_0000}, '{1'b1, 2'd2, 32'hFFFF_FFFF},
    '{1'b0, 2'd2, 32'h0000_0000}, '{1'b0, 2'd3, 32'h0000_0000}
  };

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    #1;
    n_chk = n_chk + 1;
    if (rd_data !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: addr %0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tb_tick = 1'b1;
    repeat (n) @(negedge clk);
    tb_tick = 1'b0;
  endtask

  task automatic tb_set(input logic [15:0] v);
    @(negedge clk);
    tb_val = v;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; tb_tick = 1'b0; tb_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_rd(2'd0, 32'h0, "R1 dec reset");
    chk_rd(2'd1, 32'h0, "R1 ctrl reset");
    chk_rd(2'd2, 32'h0, "R1 status reset");
    chk_bit(irq_dec | irq_fit | irq_wdt, 1'b0, "R1 irqs low");

    // vector table: R3/R4/R5 masks, MSB load, zero load
    for (int i = 0; i < 12; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else           chk_rd(VEC[i].addr, VEC[i].data, $sformatf("R3/R4/R5 table step %0d", i));
    end

    // R2 counting and halt at zero, R3 flag on 1->0, R6 late enable
    wr(2'd0, 32'd3);
    ticks(2);
    chk_rd(2'd0, 32'd1, "R2 count down");
    chk_rd(2'd2, 32'h0, "R3 no flag before zero");
    ticks(1);
    chk_rd(2'd0, 32'd0, "R2 reach zero");
    chk_rd(2'd2, 32'h1000_0000, "R3 flag on expiry");
    chk_bit(irq_dec, 1'b0, "R6 no irq with enable clear");
    ticks(3);
    chk_rd(2'd0, 32'd0, "R2 halt at zero, no wrap");
    wr(2'd1, 32'h0400_0000);
    chk_bit(irq_dec, 1'b1, "R6 late enable fires");
    wr(2'd2, 32'h0800_0000);
    chk_rd(2'd2, 32'h1000_0000, "R4 zero bit leaves flag");
    chk_bit(irq_dec, 1'b1, "R4 irq kept");
    wr(2'd2, 32'h1000_0000);
    chk_rd(2'd2, 32'h0, "R4 W1C clears flag");
    chk_bit(irq_dec, 1'b0, "R6 irq drops with flag");

    // R10 load overrides tick
    @(negedge clk);
    tb_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd5;
    @(negedge clk);
    tb_tick = 1'b0; wr_en = 1'b0;
    chk_rd(2'd0, 32'd5, "R10 load wins over tick");

    // R4 set wins over same-cycle clear
    wr(2'd0, 32'd1);
    @(negedge clk);
    tb_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1000_0000;
    @(negedge clk);
    tb_tick = 1'b0; wr_en = 1'b0;
    chk_rd(2'd2, 32'h1000_0000, "R4 set wins over clear");
    wr(2'd2, 32'hFFFF_FFFF);

    // R7 fixed-interval tap selection
    wr(2'd1, 32'h0180_0000);
    tb_set(16'h0004);
    chk_rd(2'd2, 32'h0, "R7 unselected bit ignored");
    tb_set(16'h000C);
    chk_rd(2'd2, 32'h0800_0000, "R7 selected bit rise");
    chk_bit(irq_fit, 1'b1, "R7 fit irq");
    wr(2'd2, 32'h0800_0000);

    // R9 period change, no false event on steady-high bit
    wr(2'd1, 32'h0080_0000);
    chk_rd(2'd2, 32'h0, "R9 no event on select change");
    tb_set(16'h0008);
    tb_set(16'h000C);
    chk_rd(2'd2, 32'h0800_0000, "R9 new tap active");
    wr(2'd2, 32'h0800_0000);

    // R8 watchdog two-step
    wr(2'd1, 32'h0800_0000);
    tb_set(16'h010C);
    chk_rd(2'd2, 32'h8000_0000, "R8 first watchdog event");
    chk_bit(irq_wdt, 1'b0, "R8 no irq on first event");
    tb_set(16'h000C);
    tb_set(16'h010C);
    chk_rd(2'd2, 32'hE000_0000, "R8 second watchdog event");
    chk_bit(irq_wdt, 1'b1, "R8 watchdog irq");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule